// File: doc/BRIEF.md
# Set-Associative Read Buffer Controller

This block is a read-only buffer that sits between a processor and a slower, interleaved main storage. The processor presents a 24-bit byte address with a valid strobe. The controller picks one column of the buffer from middle address bits and compares the high-order bits against the tag of every block in that column. On a hit it returns one 64-bit doubleword from the buffer and leaves main storage untouched.

On a miss the controller takes the least-recently-used block of the column as the victim. It refills that block with the 32-byte aligned line by issuing four doubleword reads on back-to-back cycles. The first read fetches the doubleword the processor asked for. That doubleword is returned to the processor as soon as it arrives and is written into the buffer in the same cycle. The other three follow in wrap-around order. Each column keeps a complete recency ordering of its blocks, and that ordering decides which block is replaced.

Main storage is a simple read port. It accepts one doubleword address per cycle and returns the data in issue order after any latency of at least one cycle.

Top module: `sa_read_buffer`

## Requirements
- R1: A request hits only if a block in column addr[10:5] is valid and holds tag addr[23:11]. An identical tag in a block whose valid bit is clear gives a miss.
- R2: On a hit, rsp_valid is high for exactly one cycle, one clock edge after the request is accepted. rsp_data is the doubleword selected by addr[4:3], addr[2:0] has no effect, and mem_req stays low.
- R3: A hit moves the referenced block to the most-recently-used position of its column's ordering. The other blocks keep their relative order.
- R4: A miss replaces the block at the least-recently-used position of its column. After reset, each column orders way 0 as most recent and way WAYS-1 as least recent.
- R5: A miss raises mem_req for exactly four consecutive cycles. mem_addr is the doubleword address {tag, column, select}, starting with the requested select and then stepping +1, +2, +3 modulo 4 within the aligned 32-byte line.
- R6: On a miss, rsp_valid pulses one clock edge after the first mem_rvalid, with rsp_data equal to that first returned doubleword, which is the requested one. The same doubleword is stored in the buffer.
- R7: Once all four doublewords have returned, the victim block is valid with the new tag. Later reads of any of its four doublewords hit and return the fetched data.
- R8: A freshly filled block takes the most-recently-used position of its column.
- R9: req_ready is low from the acceptance of a request until its hit response, or until the fourth fill doubleword of a miss has returned. A request held on req_valid during that time is neither accepted nor fetched.
- R10: Reset clears every valid bit, so an address that hit before the reset misses after it.
- R11: Fill data may return any number of cycles (at least one) after issue, even while reads are still being issued. The n-th return fills the n-th issued doubleword.
- R12: Columns are independent. A fill in one column does not change hits, victims or ordering in another column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor read request strobe |
| req_addr | input | 24 | Processor byte address |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse marking rsp_data valid |
| rsp_data | output | 64 | Returned doubleword |
| mem_req | output | 1 | Main-storage doubleword read issue |
| mem_addr | output | 21 | Main-storage doubleword address (byte address bits 23:3) |
| mem_rvalid | input | 1 | Main-storage read data valid, in issue order |
| mem_rdata | input | 64 | Main-storage read data |

## Verification
The main stimulus is a scripted sequence of reads against one column, using five tags, so that four ways are filled, overflowed and revisited. Whether each read hits or misses then shows whether the recency ordering promoted hit blocks, placed fills at the top, and chose the true bottom as victim. Each step requests a different doubleword select, and the fill latency is varied from one to four cycles. This separates a correct critical-first, wrap-around fill from one that starts at the line base or mixes up returns arriving while reads are still issuing. A second column, a request held during a busy fill, a nonzero byte offset and a mid-run reset show column independence, refusal while busy, the ignored low bits and the cleared valid bits.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } srb_state_e;
endpackage

// File: rtl/srb_dw_ram.sv
module srb_dw_ram #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/srb_tag_match.sv
module srb_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 13,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            vld_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec_o[g] = vld_i[g] && (tags_i[g] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_way_o = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec_o[i]) hit_way_o = WAY_W'(i);
    end
  end
endmodule

// File: rtl/srb_lru_promote.sv
module srb_lru_promote #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][WAY_W-1:0] order_i,  // position 0 = most recent
  input  logic [WAY_W-1:0]           use_way_i,
  output logic [WAYS-1:0][WAY_W-1:0] order_o
);
  // shift_en[i]: the promoted way sits at position i or further down
  logic [WAYS-1:0] shift_en;

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      shift_en[i] = !seen;
      if (order_i[i] == use_way_i) seen = 1'b1;
    end
  end

  assign order_o[0] = use_way_i;
  for (genvar g = 1; g < WAYS; g++) begin : g_pos
    assign order_o[g] = shift_en[g] ? order_i[g-1] : order_i[g];
  end
endmodule

// File: rtl/sa_read_buffer.sv
module sa_read_buffer #(
  parameter int ADDR_W = 24,
  parameter int DW_W   = 64,
  parameter int WAYS   = 4,
  parameter int IDX_W  = 6,
  parameter int SEL_W  = 2,
  parameter int OFS_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic                      req_ready,
  output logic                      rsp_valid,
  output logic [DW_W-1:0]           rsp_data,
  output logic                      mem_req,
  output logic [ADDR_W-OFS_W-1:0]   mem_addr,
  input  logic                      mem_rvalid,
  input  logic [DW_W-1:0]           mem_rdata
);
  import srb_pkg::*;

  localparam int TAG_W   = ADDR_W - IDX_W - SEL_W - OFS_W;
  localparam int SETS    = 1 << IDX_W;
  localparam int BEATS   = 1 << SEL_W;
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int RAM_AW  = IDX_W + SEL_W;
  localparam int CNT_W   = SEL_W + 1;

  // ---------------- request fields
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic [SEL_W-1:0] req_sel;
  logic             req_fire;

  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = req_addr[OFS_W+SEL_W +: IDX_W];
  assign req_sel  = req_addr[OFS_W +: SEL_W];
  assign req_fire = req_valid && req_ready;

  // ---------------- control state
  srb_state_e       state;
  logic [TAG_W-1:0] cur_tag;
  logic [IDX_W-1:0] cur_idx;
  logic [SEL_W-1:0] cur_sel;
  logic [WAY_W-1:0] victim;
  logic [CNT_W-1:0] iss_cnt;
  logic [SEL_W-1:0] ret_cnt;

  // ---------------- directory storage
  logic [TAG_W-1:0]            tag_q   [WAYS][SETS];
  logic [SETS-1:0]             valid_q [WAYS];
  logic [WAYS-1:0][WAY_W-1:0]  lru_q   [SETS];

  logic [WAYS-1:0][TAG_W-1:0]  look_tags;
  logic [WAYS-1:0]             look_vld;
  logic [WAYS-1:0]             hit_vec;
  logic                        hit;
  logic [WAY_W-1:0]            hit_way;

  for (genvar g = 0; g < WAYS; g++) begin : g_dir
    assign look_tags[g] = tag_q[g][cur_idx];
    assign look_vld[g]  = valid_q[g][cur_idx];
  end

  srb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_match (
    .tags_i    (look_tags),
    .vld_i     (look_vld),
    .tag_i     (cur_tag),
    .hit_vec_o (hit_vec),
    .hit_o     (hit),
    .hit_way_o (hit_way)
  );

  // ---------------- fill bookkeeping
  logic fill_ret;
  logic fill_done;
  logic look_hit;

  assign look_hit  = (state == ST_LOOK) && hit;
  assign fill_ret  = (state == ST_FILL) && mem_rvalid;
  assign fill_done = fill_ret && (ret_cnt == SEL_W'(BEATS - 1));

  // ---------------- recency ordering
  logic [WAY_W-1:0]            prom_way;
  logic [WAYS-1:0][WAY_W-1:0]  lru_next;
  logic                        lru_we;

  assign prom_way = (state == ST_LOOK) ? hit_way : victim;
  assign lru_we   = look_hit || fill_done;

  srb_lru_promote #(.WAYS(WAYS), .WAY_W(WAY_W)) i_lru (
    .order_i   (lru_q[cur_idx]),
    .use_way_i (prom_way),
    .order_o   (lru_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int p = 0; p < WAYS; p++) lru_q[s][p] <= WAY_W'(p);
      end
    end else if (lru_we) begin
      lru_q[cur_idx] <= lru_next;
    end
  end

  // valid bits reset; tags are plain storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) valid_q[w] <= '0;
    end else if (fill_done) begin
      valid_q[victim][cur_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) tag_q[victim][cur_idx] <= cur_tag;
  end

  // ---------------- data array, one RAM per way
  logic [DW_W-1:0]   rd_q [WAYS];
  logic [SEL_W-1:0]  wr_sel;
  logic [RAM_AW-1:0] wr_addr;
  logic [RAM_AW-1:0] rd_addr;

  assign wr_sel  = cur_sel + ret_cnt;
  assign wr_addr = {cur_idx, wr_sel};
  assign rd_addr = {req_idx, req_sel};

  for (genvar g = 0; g < WAYS; g++) begin : g_ram
    srb_dw_ram #(.AW(RAM_AW), .DW(DW_W)) i_ram (
      .clk   (clk),
      .we    (fill_ret && (victim == WAY_W'(g))),
      .waddr (wr_addr),
      .wdata (mem_rdata),
      .re    (req_fire),
      .raddr (rd_addr),
      .rdata (rd_q[g])
    );
  end

  // ---------------- sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      cur_tag   <= '0;
      cur_idx   <= '0;
      cur_sel   <= '0;
      victim    <= '0;
      iss_cnt   <= '0;
      ret_cnt   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_fire) begin
            cur_tag   <= req_tag;
            cur_idx   <= req_idx;
            cur_sel   <= req_sel;
            req_ready <= 1'b0;
            state     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= rd_q[hit_way];
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            victim   <= lru_q[cur_idx][WAYS-1];
            mem_req  <= 1'b1;
            mem_addr <= {cur_tag, cur_idx, cur_sel};
            iss_cnt  <= CNT_W'(1);
            ret_cnt  <= '0;
            state    <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_req) begin
            if (iss_cnt == CNT_W'(BEATS)) begin
              mem_req <= 1'b0;
            end else begin
              mem_addr[SEL_W-1:0] <= mem_addr[SEL_W-1:0] + 1'b1;
              iss_cnt             <= iss_cnt + 1'b1;
            end
          end
          if (mem_rvalid) begin
            ret_cnt <= ret_cnt + 1'b1;
            if (ret_cnt == '0) begin
              rsp_valid <= 1'b1;
              rsp_data  <= mem_rdata;
            end
            if (fill_done) begin
              mem_req   <= 1'b0;
              req_ready <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions
  assert_single_match_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  assert_hit_no_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    look_hit |=> !mem_req);

  assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_wrap_order_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |->
      (mem_addr[SEL_W-1:0] == SEL_W'($past(mem_addr[SEL_W-1:0]) + 1'b1)));

  assert_four_reads_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_req) |-> (iss_cnt == CNT_W'(BEATS)));

  assert_critical_first_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (mem_addr[SEL_W-1:0] == cur_sel));
endmodule

// File: tb/test_sa_read_buffer.sv
module test_sa_read_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        mem_req;
  logic [20:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  sa_read_buffer i_sa_read_buffer (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [63:0] exp_dw(input logic [20:0] d);
    return {22'h3C0F0F, d, ~d};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // ---------------- main storage model: in-order, programmable latency
  int          mem_lat = 1;
  int          mem_cnt = 0;
  int          cyc_n   = 0;
  int          wp = 0, rp = 0;
  logic [20:0] q_addr  [16];
  int          q_due   [16];
  logic [20:0] iss_log [16];

  always @(negedge clk) begin
    if (rst) begin
      wp = 0; rp = 0; mem_rvalid = 1'b0;
    end else begin
      if (mem_req) begin
        q_addr[wp % 16]       = mem_addr;
        q_due[wp % 16]        = cyc_n + mem_lat;
        iss_log[mem_cnt % 16] = mem_addr;
        wp++; mem_cnt++;
      end
      mem_rvalid = 1'b0;
      if (rp != wp && q_due[rp % 16] <= cyc_n) begin
        mem_rvalid = 1'b1;
        mem_rdata  = exp_dw(q_addr[rp % 16]);
        rp++;
      end
    end
    cyc_n++;
  end

  task automatic wait_ready();
    for (int k = 0; k < 100 && !req_ready; k++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic access(input logic [23:0] a, input bit exp_hit, input int lat);
    int base, n;
    bit got;
    logic [63:0] d;
    logic [20:0] e;
    mem_lat = lat;
    wait_ready();
    base = mem_cnt;
    req_valid = 1'b1; req_addr = a;
    @(negedge clk); #1;
    req_valid = 1'b0;
    n = 1; got = 1'b0; d = '0;
    while (!got && n < 60) begin
      if (rsp_valid) begin got = 1'b1; d = rsp_data; end
      else begin @(negedge clk); #1; n++; end
    end
    chk(got, "R2 R6 response arrives", 64'(got), 64'd1);
    chk(d == exp_dw(a[23:3]), exp_hit ? "R2 R7 hit data" : "R6 forwarded data",
        d, exp_dw(a[23:3]));
    if (exp_hit) chk(n == 2, "R2 hit latency", 64'(n), 64'd2);
    @(negedge clk); #1;
    chk(!rsp_valid, "R2 single pulse", 64'(rsp_valid), 64'd0);
    wait_ready();
    chk((mem_cnt - base) == (exp_hit ? 0 : 4),
        exp_hit ? "R1 R3 R7 hit no fetch" : "R1 R4 R8 R5 miss fetches four",
        64'(mem_cnt - base), exp_hit ? 64'd0 : 64'd4);
    if (!exp_hit) begin
      for (int k = 0; k < 4; k++) begin
        e = {a[23:5], 2'(a[4:3] + k)};
        chk(iss_log[(base + k) % 16] == e, "R5 R11 fill order",
            64'(iss_log[(base + k) % 16]), 64'(e));
      end
    end
  endtask

  // {expect_hit, tag13, column6, select2, byte3}
  // tags A=0A1 B=1B2 C=0C3 D=1D4 E=0E5; reset order way0..way3, way3 LRU (R4)
  localparam logic [24:0] VEC [16] = '{
    {1'b0, 13'h0A1, 6'd5, 2'd0, 3'd0},  // A miss -> way3 (R4, R8)
    {1'b1, 13'h0A1, 6'd5, 2'd2, 3'd0},  // A hit other select (R7)
    {1'b0, 13'h1B2, 6'd5, 2'd1, 3'd0},  // B -> way2
    {1'b0, 13'h0C3, 6'd5, 2'd3, 3'd0},  // C -> way1
    {1'b0, 13'h1D4, 6'd5, 2'd0, 3'd0},  // D -> way0, order D C B A
    {1'b1, 13'h0A1, 6'd5, 2'd1, 3'd0},  // A hit, promoted (R3)
    {1'b0, 13'h0E5, 6'd5, 2'd2, 3'd0},  // E evicts B (R4)
    {1'b0, 13'h1B2, 6'd5, 2'd0, 3'd0},  // B evicts C
    {1'b1, 13'h0A1, 6'd5, 2'd3, 3'd0},  // A hit
    {1'b1, 13'h1D4, 6'd5, 2'd2, 3'd0},  // D hit (R3)
    {1'b0, 13'h0C3, 6'd5, 2'd1, 3'd0},  // C evicts E
    {1'b0, 13'h0E5, 6'd5, 2'd0, 3'd0},  // E evicts B
    {1'b1, 13'h0A1, 6'd5, 2'd2, 3'd0},  // A still present
    {1'b0, 13'h0A1, 6'd6, 2'd3, 3'd0},  // other column misses (R12)
    {1'b1, 13'h0A1, 6'd6, 2'd0, 3'd0},  // R12 hit in column 6
    {1'b1, 13'h1D4, 6'd5, 2'd2, 3'd7}   // nonzero byte bits ignored (R2)
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R9 ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R2 no response after reset", 64'(rsp_valid), 64'd0);
    chk(mem_req == 1'b0, "R5 no fetch after reset", 64'(mem_req), 64'd0);

    for (int i = 0; i < 16; i++) access(VEC[i][23:0], VEC[i][24], 1 + (i % 4));

    // R9: request held while a fill is busy must be refused
    begin
      int base, rsps;
      mem_lat = 3;
      wait_ready();
      base = mem_cnt; rsps = 0;
      req_valid = 1'b1; req_addr = {13'h050, 6'd12, 2'd1, 3'd0};
      @(negedge clk); #1;
      req_addr = {13'h060, 6'd12, 2'd2, 3'd0};
      for (int k = 0; k < 60 && !req_ready; k++) begin
        if (rsp_valid) rsps++;
        @(negedge clk); #1;
      end
      req_valid = 1'b0;
      repeat (6) begin @(negedge clk); #1; if (rsp_valid) rsps++; end
      chk(rsps == 1, "R9 one response while busy", 64'(rsps), 64'd1);
      chk(mem_cnt - base == 4, "R9 no fetch for refused request",
          64'(mem_cnt - base), 64'd4);
      access({13'h050, 6'd12, 2'd2, 3'd0}, 1'b1, 2);
      access({13'h060, 6'd12, 2'd2, 3'd0}, 1'b0, 2);
    end

    // R10: reset clears valid bits
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; #1;
    chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
    access({13'h0A1, 6'd5, 2'd1, 3'd0}, 1'b0, 4);
    access({13'h0A1, 6'd5, 2'd3, 3'd0}, 1'b1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule